// File: doc/BRIEF.md
# I2C Slave Address Recognition Flags

This block follows an I2C controller while it runs as a slave receiver. It looks at the first byte that arrives after each START or repeated START. If the upper seven bits of that byte equal the programmed own address, or if the whole byte is the general call address (all zeros), it raises the sticky `addressed` flag. A general call also raises a separate `gen_call` flag, but only when the two format select inputs are not both 1.

Software clears each flag with a two-step handshake. It first reads the flag while it is 1, and then it writes 0 to it. Both flags also clear as a side effect of data register traffic that matches the current direction. The flags are held at zero whenever the controller is in master mode. Bit-level bus sampling, acknowledge generation and the shift register belong to other blocks. This block receives decoded START and byte-complete strobes, the received byte, the mode controls and the register access strobes.

Top module: `i2c_addr_flags`

## Requirements
- R1: After reset, `addressed` and `gen_call` are both 0.
- R2: On the byte-complete strobe of the first frame after a START, in slave receive mode and not master mode, `addressed` becomes 1 in the following cycle when `rx_byte[7:1]` equals `own_addr`. The direction bit `rx_byte[0]` has no influence. A byte that does not match leaves both flags at 0.
- R3: A first frame equal to 8'h00 sets `addressed`. It also sets `gen_call` unless `fmt_sel` is 2'b11.
- R4: Only the first frame after a START is examined. Later frames in the same transfer set neither flag, and a repeated START arms recognition again. No frame sets a flag while `slave_rx` is 0.
- R5: When `flag_wr` is pulsed with its data bit at 0 (`wr_addressed` for `addressed`, `wr_gencall` for `gen_call`), that flag clears, but only if a `flag_rd` pulse saw it at 1 earlier. A write of 0 without such a read is ignored. A write of 1 never sets a flag.
- R6: The read-as-1 arming is kept separately for each flag, and any clear of that flag cancels it.
- R7: Both flags clear on `data_wr` while `xmit_mode` is 1, and on `data_rd` while `xmit_mode` is 0. The opposite combinations have no effect.
- R8: While `master_mode` is 1, both flags are 0 from the next cycle onward, and no frame sets them.
- R9: When a recognition set and a clear (software or automatic) fall in the same cycle, the flag ends up 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slave_rx | input | 1 | Controller is in slave receive mode |
| master_mode | input | 1 | Controller is in master mode |
| xmit_mode | input | 1 | 1 = transmit direction, 0 = receive |
| fmt_sel | input | 2 | Format select bits; 2'b11 blocks general call flagging |
| own_addr | input | 7 | Programmed 7-bit slave address |
| start_det | input | 1 | One-cycle pulse on START or repeated START |
| byte_done | input | 1 | One-cycle pulse when a byte is complete |
| rx_byte | input | 8 | Received byte, valid with byte_done |
| flag_rd | input | 1 | Status register read strobe |
| flag_wr | input | 1 | Status register write strobe |
| wr_addressed | input | 1 | Write data bit for the addressed flag |
| wr_gencall | input | 1 | Write data bit for the general call flag |
| data_rd | input | 1 | Data register read strobe |
| data_wr | input | 1 | Data register write strobe |
| addressed | output | 1 | Own address or general call recognized |
| gen_call | output | 1 | General call recognized |

## Verification
A recognition set and a clear can fall in the same cycle. The clear can come from the software write-0 handshake or from a data register access in the matching direction. The bench arms `addressed` with a read, sends a START, and then raises the first frame's byte-complete strobe in the same cycle as a write of 0 and a receive-direction data read. It expects `addressed` to read 1 afterwards. A second collision puts `master_mode` on top of a valid first frame, and there the clear must win.

// File: rtl/i2c_addr_flags.sv
module i2c_addr_flags #(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slave_rx,
  input  logic              master_mode,
  input  logic              xmit_mode,
  input  logic [1:0]        fmt_sel,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              start_det,
  input  logic              byte_done,
  input  logic [ADDR_W:0]   rx_byte,
  input  logic              flag_rd,
  input  logic              flag_wr,
  input  logic              wr_addressed,
  input  logic              wr_gencall,
  input  logic              data_rd,
  input  logic              data_wr,
  output logic              addressed,
  output logic              gen_call
);

  logic first_pend, arm_a, arm_g;

  wire hit      = byte_done && first_pend && slave_rx && !master_mode;
  wire is_gc    = (rx_byte == '0);
  wire is_own   = (rx_byte[ADDR_W:1] == own_addr);
  wire set_a    = hit && (is_own || is_gc);
  wire set_g    = hit && is_gc && !(&fmt_sel);
  wire auto_clr = (data_wr && xmit_mode) || (data_rd && !xmit_mode);
  wire sw_clr_a = flag_wr && !wr_addressed && arm_a;
  wire sw_clr_g = flag_wr && !wr_gencall && arm_g;
  wire clr_a    = master_mode || (!set_a && (auto_clr || sw_clr_a));
  wire clr_g    = master_mode || (!set_g && (auto_clr || sw_clr_g));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      first_pend <= 1'b0;
      addressed  <= 1'b0;
      gen_call   <= 1'b0;
      arm_a      <= 1'b0;
      arm_g      <= 1'b0;
    end else begin
      if (start_det)      first_pend <= 1'b1;
      else if (byte_done) first_pend <= 1'b0;

      if (clr_a)      addressed <= 1'b0;
      else if (set_a) addressed <= 1'b1;
      if (clr_g)      gen_call  <= 1'b0;
      else if (set_g) gen_call  <= 1'b1;

      if (clr_a)                      arm_a <= 1'b0;
      else if (flag_rd && addressed)  arm_a <= 1'b1;
      if (clr_g)                      arm_g <= 1'b0;
      else if (flag_rd && gen_call)   arm_g <= 1'b1;
    end
  end

  a_r8_master_holds_clear: assert property (@(posedge clk) disable iff (!rst_n)
    master_mode |=> (!addressed && !gen_call));

  a_r3_gc_with_addr: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gen_call) |-> addressed);

  a_r4_rise_needs_byte: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(addressed) |-> $past(byte_done && slave_rx));

  a_r5_fall_needs_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(addressed) |-> $past(master_mode || data_rd || data_wr || (flag_wr && arm_a)));

  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (set_a && !master_mode) |=> addressed);

  a_r7_auto_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_clr && !set_a && !set_g) |=> (!addressed && !gen_call));

endmodule

// File: tb/i2c_addr_flags_test.sv
module i2c_addr_flags_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic slave_rx = 1'b1, master_mode = 1'b0, xmit_mode = 1'b0;
  logic [1:0] fmt_sel = 2'b00;
  logic [6:0] own_addr = 7'h2A;
  logic start_det = 0, byte_done = 0, flag_rd = 0, flag_wr = 0;
  logic wr_addressed = 0, wr_gencall = 0, data_rd = 0, data_wr = 0;
  logic [7:0] rx_byte = 8'h00;
  logic addressed, gen_call;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  i2c_addr_flags uut (.*);

  task automatic tick();
    @(negedge clk);
    start_det = 0; byte_done = 0; flag_rd = 0; flag_wr = 0;
    wr_addressed = 0; wr_gencall = 0; data_rd = 0; data_wr = 0;
  endtask

  task automatic check(string req, logic ea, logic eg);
    total++;
    if (addressed !== ea || gen_call !== eg) begin
      bad++;
      $display("FAIL %s: got a=%b g=%b expected a=%b g=%b", req, addressed, gen_call, ea, eg);
    end
  endtask

  task automatic start_pulse(); start_det = 1; tick(); endtask
  task automatic frame(logic [7:0] b); rx_byte = b; byte_done = 1; tick(); endtask
  task automatic first(logic [7:0] b); start_pulse(); frame(b); endtask
  task automatic rd(); flag_rd = 1; tick(); endtask
  task automatic wr(logic a, logic g); flag_wr = 1; wr_addressed = a; wr_gencall = g; tick(); endtask
  task automatic wipe(); master_mode = 1; tick(); master_mode = 0; endtask

  task automatic t_reset();
    check("R1 reset", 0, 0);
  endtask

  task automatic t_own();
    first(8'h55); check("R2 own addr rw=1", 1, 0);
    wipe(); first(8'h54); check("R2 own addr rw=0", 1, 0);
    wipe(); first(8'h56); check("R2 mismatch", 0, 0);
  endtask

  task automatic t_gc();
    wipe(); fmt_sel = 2'b00; first(8'h00); check("R3 gc fmt00", 1, 1);
    wipe(); fmt_sel = 2'b11; first(8'h00); check("R3 gc fmt11", 1, 0);
    wipe(); fmt_sel = 2'b10; first(8'h00); check("R3 gc fmt10", 1, 1);
    fmt_sel = 2'b00;
  endtask

  task automatic t_first_only();
    wipe(); first(8'h56); frame(8'h54); check("R4 later frame", 0, 0);
    frame(8'h00); check("R4 later gc frame", 0, 0);
    start_pulse(); frame(8'h54); check("R4 repeated start", 1, 0);
    wipe(); slave_rx = 0; first(8'h54); check("R4 not slave rx", 0, 0);
    slave_rx = 1;
  endtask

  task automatic t_sw();
    wipe(); first(8'h54);
    wr(0, 0); check("R5 write0 unarmed", 1, 0);
    rd(); wr(1, 1); check("R5 write1 no effect", 1, 0);
    wr(0, 1); check("R5 armed write0", 0, 0);
    wr(1, 1); check("R5 write1 no set", 0, 0);
  endtask

  task automatic t_arm();
    wipe(); first(8'h54); rd(); first(8'h00);
    wr(1, 0); check("R6 gc not armed", 1, 1);
    wr(0, 1); check("R6 addr armed", 0, 1);
    wipe(); first(8'h54); rd();
    xmit_mode = 1; data_wr = 1; tick(); xmit_mode = 0;
    check("R7 tx write clears", 0, 0);
    first(8'h54); wr(0, 0); check("R6 arm cancelled", 1, 0);
  endtask

  task automatic t_auto();
    wipe(); first(8'h00);
    xmit_mode = 1; data_rd = 1; tick(); check("R7 tx read ignored", 1, 1);
    xmit_mode = 0; data_wr = 1; tick(); check("R7 rx write ignored", 1, 1);
    data_rd = 1; tick(); check("R7 rx read clears", 0, 0);
  endtask

  task automatic t_master();
    wipe(); first(8'h00); check("R8 setup", 1, 1);
    master_mode = 1; tick(); check("R8 master clears", 0, 0);
    first(8'h54); check("R8 no set in master", 0, 0);
    master_mode = 0;
  endtask

  task automatic t_collide();
    wipe(); first(8'h54); rd(); start_pulse();
    rx_byte = 8'h54; byte_done = 1; flag_wr = 1; data_rd = 1; tick();
    check("R9 set beats clear", 1, 0);
    start_pulse(); rx_byte = 8'h00; byte_done = 1; master_mode = 1; tick();
    master_mode = 0; check("R8 master beats set", 0, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: got hang expected finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk); rst_n = 1;
    t_reset(); t_own(); t_gc(); t_first_only(); t_sw(); t_arm(); t_auto(); t_master(); t_collide();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule